// File: doc/BRIEF.md
# Nine-Level Dual-Rate Carrier PWM Generator

This block drives the eight gate commands of one phase leg of a nine-level inverter. The leg is built from two cascaded full bridges with a 1:3 supply ratio. A signed sampled sine reference is compared every clock against eight stacked triangular carriers of equal height. Together the carrier bands cover the full reference range. Two programmable ramp generators feed the stack. Each carrier takes the fast or the slow ramp according to a fixed symmetric pairing about the zero line. A two-bit disposition input selects which bands use the inverted ramp: none of them, the lower half, or every second band.

The comparator results form a thermometer code, and its count is converted to a target level between -4 and +4. A registered output level moves toward that target by at most one step per clock. The level is then split into the states of the two bridges, the coarse 3-unit bridge and the fine 1-unit bridge, each -1, 0 or +1. The states are decoded into switch pairs. On each new entry into the zero state, a bridge alternates between its two zero-state switch pairs.

Top module: `vfpwm_phase`

## Requirements
- R1: With B = 2^(REF_W-3), band k (k = 0 at the top, 7 at the bottom) has its lower edge at (3-k)*B. Its carrier is lower edge + p, where p is the ramp position 0..B-1. A band counts as asserted when the signed reference is strictly greater than its carrier. The target level is the number of asserted bands minus 4.
- R2: Bands 0, 2, 5 and 7 use the fast ramp (fast_div_i), and bands 1, 3, 4 and 6 use the slow ramp (slow_div_i). Each band therefore shares its rate with its mirror band 7-k.
- R3: Each ramp advances one position every D clocks, where D is its divider input and a divider of 0 acts as 1. After reset a ramp starts at 0 and rises. It turns around at B-1 and at 0, so it passes through every position in between.
- R4: disp_mode_i selects the carrier disposition. 0 = no band inverted. 1 = bands 4..7 inverted. 2 = odd bands inverted. 3 behaves as 0. An inverted band uses p' = B-1-p in place of p.
- R5: level_o stays within -4..+4. Each clock it moves one step toward the target, or holds if it already equals the target.
- R6: coarse_o is +1 when the level is 2 or more, -1 when it is -2 or less, and 0 otherwise. fine_o equals level - 3*coarse_o, so fine_o + 3*coarse_o always equals level_o.
- R7: gate_o[3:0] drives the fine bridge and gate_o[7:4] drives the coarse bridge. Within each nibble, bit 0 is S1, bit 1 is S2, bit 2 is S3 and bit 3 is S4. State +1 turns on S1 and S4. State -1 turns on S2 and S3. State 0 turns on either S1+S2 or S3+S4. S1 and S3 are never on together, and neither are S2 and S4.
- R8: Each bridge holds a zero-pair selector that is cleared by reset, and a cleared selector picks S1+S2. The selector toggles each time the bridge state enters 0 from a non-zero state.
- R9: While rst_n is low, level_o is 0 and gate_o is 8'h33.
- R10: level_o is updated at the clock edge from the reference, mode and ramp positions present before that edge. gate_o, fine_o and coarse_o describe the same updated level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_mode_i | input | 2 | Carrier disposition select |
| fast_div_i | input | DIV_W | Clocks per step of the fast ramp |
| slow_div_i | input | DIV_W | Clocks per step of the slow ramp |
| ref_i | input | REF_W | Signed sampled reference |
| level_o | output | 4 | Signed output level, -4..+4 |
| fine_o | output | 2 | Signed state of the 1-unit bridge |
| coarse_o | output | 2 | Signed state of the 3-unit bridge |
| gate_o | output | 8 | Switch commands for both bridges |

## Verification
Some properties are checked by assertions on every cycle. These are the ramp step size and hold, the thermometer shape of the comparator bank, the level range and its one-step slew, the bridge recombination, the absence of leg shoot-through with exactly two switches on per bridge, and the toggling of the zero-pair selector on each zero entry. Other behaviour can only be shown by the bench's scenarios against its behavioural model, compared every clock. This covers the exact band placement and ramp pairing, the inversion pattern of each disposition including the reserved code, the divider-zero case, and the order in which the zero pairs alternate. It also covers full-scale reference steps that force the slew limit.

// File: rtl/vfpwm_pkg.sv
package vfpwm_pkg;

  typedef enum logic [1:0] {
    DISP_ALIGNED = 2'd0,
    DISP_SPLIT   = 2'd1,
    DISP_ALTERN  = 2'd2,
    DISP_SPARE   = 2'd3
  } disp_e;

  typedef logic signed [1:0] tern_t;

  localparam tern_t T_POS  = 2'sd1;
  localparam tern_t T_ZERO = 2'sd0;
  localparam tern_t T_NEG  = -2'sd1;

  // band k uses the fast ramp when it sits in the fast mirror pairs
  function automatic logic band_is_fast(input int k);
    return (k == 0) || (k == 2) || (k == 5) || (k == 7);
  endfunction

  // which bands run on the inverted ramp for a disposition
  function automatic logic band_inverted(input disp_e m, input int k);
    case (m)
      DISP_SPLIT:  return k >= 4;
      DISP_ALTERN: return (k % 2) == 1;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic tern_t coarse_of(input logic signed [3:0] lv);
    if (lv >= 4'sd2)       return T_POS;
    else if (lv <= -4'sd2) return T_NEG;
    else                   return T_ZERO;
  endfunction

  function automatic tern_t fine_of(input logic signed [3:0] lv);
    logic signed [3:0] c4;
    logic signed [3:0] r;
    c4 = coarse_of(lv);
    r  = lv - c4 - c4 - c4;
    return tern_t'(r[1:0]);
  endfunction

endpackage

// File: rtl/vfpwm_ramp.sv
module vfpwm_ramp #(
  parameter int TW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_i,
  output logic [TW-1:0] ramp_o
);
  localparam logic [TW-1:0] TOP = '1;

  logic [DW-1:0] pre_q;
  logic          up_q;
  logic [TW-1:0] ramp_q;
  logic          tick;

  assign tick   = ({1'b0, pre_q} + (DW+1)'(1)) >= {1'b0, div_i};
  assign ramp_o = ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      up_q   <= 1'b1;
      ramp_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      if (up_q) begin
        if (ramp_q == TOP) begin
          up_q   <= 1'b0;
          ramp_q <= TOP - 1'b1;
        end else begin
          ramp_q <= ramp_q + 1'b1;
        end
      end else begin
        if (ramp_q == '0) begin
          up_q   <= 1'b1;
          ramp_q <= TW'(1);
        end else begin
          ramp_q <= ramp_q - 1'b1;
        end
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R3
  ramp_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_q != $past(ramp_q)) |->
      ((ramp_q == $past(ramp_q) + 1'b1) || (ramp_q == $past(ramp_q) - 1'b1)));

  // R3
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(ramp_q));

endmodule

// File: rtl/vfpwm_cmpbank.sv
module vfpwm_cmpbank
  import vfpwm_pkg::*;
#(
  parameter int RW = 12,
  localparam int TW = RW - 3
) (
  input  logic signed [RW-1:0] ref_i,
  input  disp_e                mode_i,
  input  logic [TW-1:0]        fast_i,
  input  logic [TW-1:0]        slow_i,
  output logic [7:0]           above_o
);
  localparam int B = 1 << TW;

  logic signed [RW:0] ref_x;
  assign ref_x = $signed({ref_i[RW-1], ref_i});

  for (genvar k = 0; k < 8; k++) begin : g_band
    localparam int LOW = (3 - k) * B;
    logic [TW-1:0]    src;
    logic [TW-1:0]    pos;
    logic signed [RW:0] carrier;

    assign src        = band_is_fast(k) ? fast_i : slow_i;
    assign pos        = band_inverted(mode_i, k) ? ~src : src;
    assign carrier    = (RW+1)'(LOW) + (RW+1)'(pos);
    assign above_o[k] = ref_x > carrier;
  end

endmodule

// File: rtl/vfpwm_bridge.sv
module vfpwm_bridge
  import vfpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tern_t      st_next,
  output tern_t      st_o,
  output logic [3:0] gate_o
);
  tern_t st_q;
  logic  zsel_q;
  logic  enter_zero;

  assign enter_zero = (st_next == T_ZERO) && (st_q != T_ZERO);
  assign st_o       = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_ZERO;
      zsel_q <= 1'b0;
    end else begin
      st_q <= st_next;
      if (enter_zero) zsel_q <= ~zsel_q;
    end
  end

  // bit order: [0]=S1 [1]=S2 [2]=S3 [3]=S4
  always_comb begin
    if (st_q == T_POS)      gate_o = 4'b1001;
    else if (st_q == T_NEG) gate_o = 4'b0110;
    else                    gate_o = zsel_q ? 4'b1100 : 4'b0011;
  end

  // R7
  leg_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[2]) && !(gate_o[1] && gate_o[3]));

  // R7
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_o) == 2);

  // R8
  zero_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_ZERO && $past(st_q) != T_ZERO) |-> (zsel_q != $past(zsel_q)));

  // R6
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'sb10);

endmodule

// File: rtl/vfpwm_phase.sv
module vfpwm_phase
  import vfpwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int DIV_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              disp_mode_i,
  input  logic [DIV_W-1:0]        fast_div_i,
  input  logic [DIV_W-1:0]        slow_div_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic signed [3:0]       level_o,
  output logic signed [1:0]       fine_o,
  output logic signed [1:0]       coarse_o,
  output logic [7:0]              gate_o
);
  localparam int RAMP_W = REF_W - 3;

  disp_e             mode;
  logic [RAMP_W-1:0] ramp_f;
  logic [RAMP_W-1:0] ramp_s;
  logic [7:0]        above;
  logic [3:0]        n_above;
  logic signed [4:0] target;
  logic signed [4:0] lvl_x;
  logic signed [3:0] level_q;
  logic signed [3:0] level_d;
  tern_t             fine_d;
  tern_t             coarse_d;

  assign mode = disp_e'(disp_mode_i);

  vfpwm_ramp #(.TW(RAMP_W), .DW(DIV_W)) u_ramp_fast (
    .clk(clk), .rst_n(rst_n), .div_i(fast_div_i), .ramp_o(ramp_f));

  vfpwm_ramp #(.TW(RAMP_W), .DW(DIV_W)) u_ramp_slow (
    .clk(clk), .rst_n(rst_n), .div_i(slow_div_i), .ramp_o(ramp_s));

  vfpwm_cmpbank #(.RW(REF_W)) u_cmp (
    .ref_i(ref_i), .mode_i(mode), .fast_i(ramp_f), .slow_i(ramp_s),
    .above_o(above));

  assign n_above = 4'($countones(above));
  assign target  = $signed({1'b0, n_above}) - 5'sd4;
  assign lvl_x   = {level_q[3], level_q};

  always_comb begin
    if (target > lvl_x)      level_d = level_q + 4'sd1;
    else if (target < lvl_x) level_d = level_q - 4'sd1;
    else                     level_d = level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 4'sd0;
    else        level_q <= level_d;
  end

  assign fine_d   = fine_of(level_d);
  assign coarse_d = coarse_of(level_d);
  assign level_o  = level_q;

  vfpwm_bridge u_fine (
    .clk(clk), .rst_n(rst_n), .st_next(fine_d), .st_o(fine_o),
    .gate_o(gate_o[3:0]));

  vfpwm_bridge u_coarse (
    .clk(clk), .rst_n(rst_n), .st_next(coarse_d), .st_o(coarse_o),
    .gate_o(gate_o[7:4]));

  // R1
  thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (above[6:0] & ~above[7:1]) == 7'd0);

  // R5
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q >= -4'sd4) && (level_q <= 4'sd4));

  // R5
  level_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == $past(level_q)) || (level_q == $past(level_q) + 4'sd1) ||
    (level_q == $past(level_q) - 4'sd1));

  // R6
  recombine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == 4'(fine_o) + 4'(coarse_o) + 4'(coarse_o) + 4'(coarse_o));

endmodule

// File: tb/test_vfpwm_phase.sv
`timescale 1ns/1ps
module test_vfpwm_phase;
  localparam int RW   = 10;
  localparam int DW   = 8;
  localparam int B    = 1 << (RW - 3);
  localparam int MAXA = 4 * B - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           mode = 2'd0;
  logic [DW-1:0]        fdiv = 8'd3;
  logic [DW-1:0]        sdiv = 8'd4;
  logic signed [RW-1:0] ref_s = '0;
  logic signed [3:0]    level;
  logic signed [1:0]    fine;
  logic signed [1:0]    coarse;
  logic [7:0]           gates;

  always #2.5 clk = ~clk;

  vfpwm_phase #(.REF_W(RW), .DIV_W(DW)) i_vfpwm_phase (
    .clk(clk), .rst_n(rst_n), .disp_mode_i(mode), .fast_div_i(fdiv),
    .slow_div_i(sdiv), .ref_i(ref_s), .level_o(level), .fine_o(fine),
    .coarse_o(coarse), .gate_o(gates));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit run_cmp = 1'b0;
  bit have_prev = 1'b0;
  int prev_lvl = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // behavioural model: two ramps, a level, two bridge states with zero selectors
  int m_pre[2], m_ramp[2], m_up[2], m_st[2], m_z[2];
  int m_lvl;

  function automatic int gate_nib(input int st, input int z);
    if (st == 1)  return 9;
    if (st == -1) return 6;
    return z ? 12 : 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_pre[g] = 0; m_ramp[g] = 0; m_up[g] = 1; m_st[g] = 0; m_z[g] = 0;
      end
      m_lvl = 0;
    end else begin
      int tgt, r, md, co, fi;
      r = ref_s;
      md = mode;
      tgt = -4;
      for (int k = 0; k < 8; k++) begin
        int src, inv, car;
        src = (k == 0 || k == 2 || k == 5 || k == 7) ? m_ramp[0] : m_ramp[1];
        inv = (md == 1 && k >= 4) || (md == 2 && (k % 2) == 1);
        car = (3 - k) * B + (inv ? (B - 1 - src) : src);
        if (r > car) tgt++;
      end
      if (tgt > m_lvl) m_lvl++;
      else if (tgt < m_lvl) m_lvl--;
      co = (m_lvl >= 2) ? 1 : ((m_lvl <= -2) ? -1 : 0);
      fi = m_lvl - 3 * co;
      for (int b = 0; b < 2; b++) begin
        int ns;
        ns = (b == 1) ? co : fi;
        if (ns == 0 && m_st[b] != 0) m_z[b] ^= 1;
        m_st[b] = ns;
      end
      for (int g = 0; g < 2; g++) begin
        int d;
        d = (g == 0) ? int'(fdiv) : int'(sdiv);
        if (m_pre[g] + 1 >= d) begin
          m_pre[g] = 0;
          if (m_up[g] != 0) begin
            if (m_ramp[g] == B - 1) begin m_up[g] = 0; m_ramp[g] = B - 2; end
            else m_ramp[g]++;
          end else begin
            if (m_ramp[g] == 0) begin m_up[g] = 1; m_ramp[g] = 1; end
            else m_ramp[g]--;
          end
        end else begin
          m_pre[g]++;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (run_cmp) begin
      int lv;
      lv = level;
      chk("R1/R2/R3/R4/R5/R10 level", lv, m_lvl);
      chk("R6 fine state", int'(fine), m_st[0]);
      chk("R6 coarse state", int'(coarse), m_st[1]);
      chk("R7/R8 fine gates", int'(gates[3:0]), gate_nib(m_st[0], m_z[0]));
      chk("R7/R8 coarse gates", int'(gates[7:4]), gate_nib(m_st[1], m_z[1]));
      chk("R5 range", int'(lv >= -4 && lv <= 4), 1);
      if (have_prev) chk("R5 one step", int'(lv - prev_lvl <= 1 && prev_lvl - lv <= 1), 1);
      chk("R6 recombine", int'(fine) + 3 * int'(coarse), lv);
      prev_lvl = lv;
      have_prev = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic run_sine(input int md, input real ma, input int n);
    @(negedge clk);
    mode = 2'(md);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_s = RW'($rtoi(ma * MAXA * $sin(2.0 * 3.14159265358979 * real'(i) / real'(n))));
    end
  endtask

  task automatic hold_ref(input int v, input int n);
    @(negedge clk);
    ref_s = RW'(v);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset level", int'(level), 0);
    chk("R9 reset gates", int'(gates), 8'h33);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    run_sine(0, 1.0, 8000);   // R4 aligned
    run_sine(1, 0.9, 8000);   // R4 split halves
    run_sine(2, 0.8, 8000);   // R4 alternating
    run_sine(3, 0.95, 4000);  // R4 spare code acts as aligned
    fdiv = 8'd0;              // R3 divider zero acts as one
    sdiv = 8'd1;
    run_sine(1, 1.0, 4000);
    hold_ref(-MAXA, 30);      // R5 full-scale steps force the slew limit
    hold_ref(MAXA, 30);
    hold_ref(0, 30);
    summary();
    $finish;
  end
endmodule